// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block holds the single reservation that lets a processor build an atomic read-modify-write out of a load-and-reserve followed by a store-conditional. A load-reserve records the aligned 32-byte granule it touched and sets a valid flag. A later store-conditional is told, one cycle after it is presented, whether that flag still held. The store may be performed only on a pass. Either way, the store-conditional consumes the reservation.

Writes and invalidates that other bus masters put on the bus are snooped. One that lands anywhere inside the reserved granule kills the reservation. The valid flag is driven straight from a flop onto a status pin, so it moves only on the bus clock edge. The address compare looks only at the bits above the granule offset, which the parameter `GRAN_LSB` sets (default 5, giving 32-byte granules).

Top module: `resv_unit`

## Requirements
- R1: A load-reserve (`lr_valid_i` high at an edge) sets the reservation and captures bits [ADDR_W-1:GRAN_LSB] of `lr_addr_i`. `resv_o` is high after that edge.
- R2: A store-conditional (`sc_valid_i` high at an edge) with the reservation valid and no snoop hit in the same cycle gives `sc_done_o`=1 and `sc_pass_o`=1 for exactly the one cycle after that edge.
- R3: A store-conditional with no valid reservation gives `sc_done_o`=1 and `sc_pass_o`=0 in the cycle after that edge.
- R4: Every store-conditional clears the reservation at its edge, whether it passes or fails. `resv_o` is low afterwards unless a load-reserve is presented in the same cycle.
- R5: A snoop (`snoop_valid_i`) whose address matches the reserved granule in bits [ADDR_W-1:GRAN_LSB] clears `resv_o` at that edge. Bits [GRAN_LSB-1:0] are ignored. A snoop to any other granule leaves the reservation intact.
- R6: When a snoop hit and a store-conditional arrive in the same cycle, the snoop wins and the store-conditional reports `sc_pass_o`=0.
- R7: Only one reservation exists. A new load-reserve replaces the stored granule, so snoops then match only the newer granule.
- R8: A load-reserve in the same cycle as a store-conditional or a snoop hit leaves the new reservation valid. The store-conditional in that cycle is judged against the reservation as it stood before the edge.
- R9: While `rst_ni` is low, `resv_o`, `sc_done_o` and `sc_pass_o` are 0.
- R10: `sc_pass_o` is never high without `sc_done_o`, and `resv_o` changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lr_valid_i | input | 1 | Load-reserve request this cycle |
| lr_addr_i | input | ADDR_W | Address of the load-reserve |
| sc_valid_i | input | 1 | Store-conditional check request this cycle |
| snoop_valid_i | input | 1 | Write or invalidate from another master this cycle |
| snoop_addr_i | input | ADDR_W | Address of the snooped transaction |
| sc_done_o | output | 1 | One-cycle strobe: store-conditional result valid |
| sc_pass_o | output | 1 | Store-conditional may proceed (qualified by sc_done_o) |
| resv_o | output | 1 | Registered reservation status |

## Verification
The bench drives thousands of pseudo-random cycles and mixes load-reserve, store-conditional and snoop in every combination. Snoop addresses land inside the reserved granule at various offsets, in the neighbouring granule, and far away. A compare that includes the offset bits would miss in-granule snoops and leave a stale reservation that passes. A compare that drops a tag bit would wrongly kill the reservation on the adjacent granule. Directed cycles cover the remaining priority cases. A snoop hit in the same cycle as a store-conditional must fail it; a design that checks only the stored flag would pass it. A store-conditional that fails must still consume the reservation, and a load-reserve issued alongside a snoop or a store-conditional must survive.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef struct packed {
    logic done;
    logic pass;
  } sc_rsp_t;

  typedef enum logic [1:0] {
    RV_HOLD = 2'd0,
    RV_SET  = 2'd1,
    RV_KILL = 2'd2
  } rv_op_e;
endpackage

// File: rtl/resv_granule_cmp.sv
module resv_granule_cmp #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5,
  localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = (addr_i[ADDR_W-1:GRAN_LSB] == tag_i);

  generate
    if (GRAN_LSB > 0) begin : g_off
      logic unused_off;
      assign unused_off = ^addr_i[GRAN_LSB-1:0];
    end
  endgenerate
endmodule

// File: rtl/resv_track.sv
module resv_track
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5,
  localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_i,
  input  logic [ADDR_W-1:0] lr_addr_i,
  input  logic              kill_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o
);
  rv_op_e           op;
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  // new reservation outranks any kill of the old one
  always_comb begin
    if (lr_i)        op = RV_SET;
    else if (kill_i) op = RV_KILL;
    else             op = RV_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      unique case (op)
        RV_SET: begin
          valid_q <= 1'b1;
          tag_q   <= lr_addr_i[ADDR_W-1:GRAN_LSB];
        end
        RV_KILL: valid_q <= 1'b0;
        default: ;
      endcase
    end
  end

  generate
    if (GRAN_LSB > 0) begin : g_off
      logic unused_lr_off;
      assign unused_lr_off = ^lr_addr_i[GRAN_LSB-1:0];
    end
  endgenerate

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  AST_LR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_i |=> (valid_q && tag_q == $past(lr_addr_i[ADDR_W-1:GRAN_LSB]))); // R1
  AST_KILL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && !lr_i) |=> !valid_q); // R4
  AST_TAG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lr_i |=> $stable(tag_q)); // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lr_i && !valid_q) |=> !valid_q); // R10
endmodule

// File: rtl/resv_sc_eval.sv
module resv_sc_eval
  import resv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sc_i,
  input  logic resv_valid_i,
  input  logic snoop_hit_i,
  output logic done_o,
  output logic pass_o
);
  sc_rsp_t rsp_d, rsp_q;

  // snoop hit this cycle beats a still-set flag
  always_comb begin
    rsp_d.done = sc_i;
    rsp_d.pass = sc_i & resv_valid_i & ~snoop_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= '0;
    else         rsp_q <= rsp_d;
  end

  assign done_o = rsp_q.done;
  assign pass_o = rsp_q.pass;

  AST_PASS_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_q.pass |-> rsp_q.done); // R10
  AST_DONE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_i |=> !rsp_q.done); // R2
  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_i |=> rsp_q.done); // R2
  AST_NO_RESV_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && !resv_valid_i) |=> !rsp_q.pass); // R3
  AST_SNOOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i && snoop_hit_i) |=> !rsp_q.pass); // R6
endmodule

// File: rtl/resv_unit.sv
module resv_unit
  import resv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5,
  localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lr_valid_i,
  input  logic [ADDR_W-1:0] lr_addr_i,
  input  logic              sc_valid_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              sc_done_o,
  output logic              sc_pass_o,
  output logic              resv_o
);
  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  logic             gran_match;
  logic             snoop_hit;
  logic             kill;

  resv_granule_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
    .tag_i  (resv_tag),
    .addr_i (snoop_addr_i),
    .hit_o  (gran_match)
  );

  assign snoop_hit = snoop_valid_i & resv_valid & gran_match;
  assign kill      = sc_valid_i | snoop_hit;

  resv_track #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lr_i      (lr_valid_i),
    .lr_addr_i (lr_addr_i),
    .kill_i    (kill),
    .valid_o   (resv_valid),
    .tag_o     (resv_tag)
  );

  resv_sc_eval u_sc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sc_i         (sc_valid_i),
    .resv_valid_i (resv_valid),
    .snoop_hit_i  (snoop_hit),
    .done_o       (sc_done_o),
    .pass_o       (sc_pass_o)
  );

  assign resv_o = resv_valid;

  AST_SC_CONSUMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_valid_i && !lr_valid_i) |=> !resv_o); // R4
  AST_SNOOP_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && resv_o && !lr_valid_i &&
     snoop_addr_i[ADDR_W-1:GRAN_LSB] == resv_tag) |=> !resv_o); // R5
  AST_LR_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_valid_i |=> resv_o); // R8
endmodule

// File: tb/tb_resv_unit.sv
module tb_resv_unit;
  localparam int AW = 32;
  localparam int GL = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lr_v = 1'b0, sc_v = 1'b0, sn_v = 1'b0;
  logic [AW-1:0] lr_a = '0, sn_a = '0;
  logic          done, pass, resv;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  bit            m_valid = 1'b0;
  logic [AW-1:0] m_tag = '0;
  logic [31:0]   lfsr = 32'hACE1_1234;

  always #4 clk = ~clk;

  resv_unit #(.ADDR_W(AW), .GRAN_LSB(GL)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lr_valid_i(lr_v), .lr_addr_i(lr_a),
    .sc_valid_i(sc_v),
    .snoop_valid_i(sn_v), .snoop_addr_i(sn_a),
    .sc_done_o(done), .sc_pass_o(pass), .resv_o(resv)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, sample 2ns after posedge
  task automatic step(input bit lr, input logic [AW-1:0] la, input bit sc,
                      input bit sn, input logic [AW-1:0] sa);
    bit hit, e_pass;
    string rq;
    @(negedge clk);
    lr_v = lr; lr_a = la; sc_v = sc; sn_v = sn; sn_a = sa;
    hit    = sn && m_valid && ((sa >> GL) == m_tag);
    e_pass = sc && m_valid && !hit;
    if (lr) begin
      m_valid = 1'b1; m_tag = la >> GL;
    end else if (sc || hit) m_valid = 1'b0;
    @(posedge clk); #2;
    if (sc) rq = hit ? "R6" : (e_pass ? "R2" : "R3");
    else    rq = "R2";
    chk(rq, done, sc);
    chk(rq, pass, e_pass);
    if (lr && (sc || hit)) rq = "R8";
    else if (lr)           rq = "R1";
    else if (sc)           rq = "R4";
    else if (sn)           rq = "R5";
    else                   rq = "R7";
    chk(rq, resv, m_valid);
    @(negedge clk);
    lr_v = 0; sc_v = 0; sn_v = 0;
  endtask

  function automatic logic [AW-1:0] pick(input logic [31:0] r);
    case (r[2:0])
      3'd0, 3'd1: pick = 32'h0000_1000 | {27'd0, r[7:3]};
      3'd2:       pick = 32'h0000_1020 | {27'd0, r[7:3]};
      3'd3:       pick = 32'h0000_0FE0 | {27'd0, r[7:3]};
      3'd4:       pick = 32'h8000_1000 | {27'd0, r[7:3]};
      default:    pick = 32'h0000_2000 | {27'd0, r[7:3]};
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R9", resv, 1'b0);
    chk("R9", done, 1'b0);
    chk("R9", pass, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R3: sc with no reservation fails
    step(0, 0, 1, 0, 0);
    // R1, R2: lr then sc passes
    step(1, 32'h0000_1004, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    // R4: second sc fails, reservation consumed
    step(0, 0, 1, 0, 0);
    // R5: in-granule snoop at offset 0x1F kills
    step(1, 32'h0000_1000, 0, 0, 0);
    step(0, 0, 0, 1, 32'h0000_101F);
    step(0, 0, 1, 0, 0);
    // R5: neighbour granule snoop is ignored, sc passes
    step(1, 32'h0000_1000, 0, 0, 0);
    step(0, 0, 0, 1, 32'h0000_1020);
    step(0, 0, 0, 1, 32'h0000_0FFF);
    step(0, 0, 1, 0, 0);
    // R6: snoop hit with sc in same cycle
    step(1, 32'h0000_1000, 0, 0, 0);
    step(0, 0, 1, 1, 32'h0000_1008);
    // R7: replacement granule
    step(1, 32'h0000_1000, 0, 0, 0);
    step(1, 32'h0000_3000, 0, 0, 0);
    step(0, 0, 0, 1, 32'h0000_1000);
    step(0, 0, 0, 1, 32'h0000_3010);
    // R8: lr alongside sc and alongside snoop hit
    step(1, 32'h0000_1000, 0, 0, 0);
    step(1, 32'h0000_2000, 1, 0, 0);
    step(1, 32'h0000_2000, 0, 1, 32'h0000_2004);
    step(0, 0, 1, 0, 0);

    // near-exhaustive mixed sweep
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[10:8] == 3'd0, pick(lfsr[20:13]), lfsr[12:11] == 2'd0,
           lfsr[23:22] != 2'd0, pick(lfsr[31:24]));
    end

    // R9: reset mid-reservation
    step(1, 32'h0000_1000, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9", resv, 1'b0);
    chk("R9", done, 1'b0);
    @(negedge clk); rst_n = 1'b1; m_valid = 1'b0;
    step(0, 0, 1, 0, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule